// File: doc/BRIEF.md
# Serial Log-Domain Check-Node Processor

This block computes the new check-to-variable messages for one row of a parity-check matrix in a layered belief-propagation decoder. It runs in two passes. In the collect pass it takes one variable-to-check LLR per cycle. The row's length is not fixed: a flag on the final edge closes the row. Each LLR is split into a sign and a magnitude. The magnitude is mapped through the transform f(x) = ln((e^x+1)/(e^x-1)). The block keeps a running sum of the transformed magnitudes and a running XOR of the signs. Per-edge values are parked in a small buffer.

In the emit pass the block replays the buffered edges in their arrival order. For each edge it removes that edge's own contribution from the totals, applies f a second time to the remaining sum, and puts the combined sign on the result. Because it handles one edge per cycle, the same hardware serves rows of any degree up to a parameter limit. Both streams use valid/ready handshakes. The two passes take turns, so the input and output streams are never active together.

Top module: `cnp_serial`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: An LLR is a signed two's-complement value with 2 fractional bits. Negative values have sign 1, and zero counts as positive. The table index is |LLR| saturated at 31, including for -128. Table entry i is round(4*ln((e^x+1)/(e^x-1))) with x = i/4, saturated at 31. Entry 0 equals entry 1.
- R3: The output for edge j has magnitude T(min(S - T_j, 31)), where S is the sum of the table values of all edges in the row and T_j is edge j's own value. Its sign is the XOR of the signs of all other edges. A sign of 1 yields the two's-complement negation of the magnitude.
- R4: Each row yields exactly one output per input edge, in input order. out_last is high on the final output only.
- R5: Once the edge carrying in_last is accepted, in_ready stays low until the row's last output has been taken. in_ready rises in the cycle after that transfer.
- R6: A row reaching MAX_DEG (32) edges without in_last is closed at its 32nd edge, exactly as if in_last had been set there.
- R7: While out_valid is high and out_ready is low, out_valid, out_llr and out_last hold their values.
- R8: A single-edge row produces one output whose value is +T(0), whatever that edge's sign.
- R9: in_ready and out_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input edge LLR is valid |
| in_ready | output | 1 | Block accepts an input edge |
| in_llr | input | LLR_W (8) | Variable-to-check LLR, signed, 2 fractional bits |
| in_last | input | 1 | Marks the final edge of the row |
| out_valid | output | 1 | Output message is valid |
| out_ready | input | 1 | Consumer takes the output message |
| out_llr | output | LLR_W (8) | Check-to-variable LLR, signed |
| out_last | output | 1 | Marks the final output of the row |

## Verification
The bench drives several row patterns:
- Rows with only positive small values check the magnitude path with no sign activity.
- Rows with mixed signs isolate the exclude-own sign rule.
- Rows with extreme values such as 127, -128 and 0 exercise index saturation and the clamped zero entry.
- Single-edge rows, two-edge rows and an unterminated 32-edge row probe the degree limits.
- Random rows run under random output back-pressure. They show whether buffered order and held outputs survive stalls and whether the two passes keep apart.

// File: rtl/cnp_pkg.sv
// Package for the serial check-node processor.
// Holds the pass-phase type and the constant function that builds the
// f transform table at elaboration. Assumes idx >= 0 and frac small.
package cnp_pkg;

    typedef enum logic {
        PH_COLLECT = 1'b0,
        PH_EMIT    = 1'b1
    } cnp_phase_e;

    // Table value for one index: f(idx / 2^frac) in the same fixed point, saturated.
    function automatic int f_entry(input int idx, input int frac, input int maxv);
        real x;
        real ex;
        real y;
        int  r;
        int  i2;
        i2 = (idx == 0) ? 1 : idx;
        x  = real'(i2) / real'(1 << frac);
        ex = $exp(x);
        y  = $ln((ex + 1.0) / (ex - 1.0));
        r  = $rtoi(y * real'(1 << frac) + 0.5);
        if (r > maxv) r = maxv;
        return r;
    endfunction

endpackage

// File: rtl/cnp_ftable.sv
// Combinational f(x) lookup.
// Saturates an unsigned magnitude to the table index range, then reads a
// table computed at elaboration. Assumes input and output share FRAC bits.
module cnp_ftable #(
    parameter int IN_W  = 8,
    parameter int IDX_W = 5,
    parameter int FRAC  = 2
) (
    input  logic [IN_W-1:0]  mag,
    output logic [IDX_W-1:0] fval
);
    localparam int TMAX    = (1 << IDX_W) - 1;
    localparam int ENTRIES = 1 << IDX_W;

    logic [IDX_W-1:0] tbl [ENTRIES];
    logic [IDX_W-1:0] idx;

    // Fill each table slot from the constant function.
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_tbl
        localparam int FV = cnp_pkg::f_entry(gi, FRAC, TMAX);
        assign tbl[gi] = IDX_W'(FV);
    end

    // Saturate the magnitude into the index range.
    always_comb begin
        if (IN_W > IDX_W && mag > IN_W'(TMAX)) idx = IDX_W'(TMAX);
        else                                   idx = IDX_W'(mag);
    end

    assign fval = tbl[idx];
endmodule

// File: rtl/cnp_edge_fifo.sv
// Small circular buffer holding one {sign, f value} word per edge of a row.
// Assumes the caller never pushes when full nor pops when empty.
module cnp_edge_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q;
    logic [PW-1:0] rd_q;
    logic [CW-1:0] cnt_q;

    // Store the pushed word.
    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    // Advance pointers with wrap and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout  = mem[rd_q];
    assign count = cnt_q;
endmodule

// File: rtl/cnp_serial.sv
// Serial log-domain check-node processor (top).
// Collect pass: abs stage, then f lookup, with the sign delayed two stages
// alongside; totals are accumulated and each edge is buffered.
// Emit pass: per edge, removes its own term, applies f again, sets the sign.
// Assumes rows of at most MAX_DEG edges; longer rows are cut at MAX_DEG.
module cnp_serial #(
    parameter int LLR_W   = 8,
    parameter int IDX_W   = 5,
    parameter int FRAC    = 2,
    parameter int MAX_DEG = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LLR_W-1:0] in_llr,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LLR_W-1:0] out_llr,
    output logic             out_last
);
    import cnp_pkg::*;

    localparam int F_W   = IDX_W;
    localparam int SUM_W = F_W + $clog2(MAX_DEG) + 1;
    localparam int CNT_W = $clog2(MAX_DEG + 1);
    localparam int BUF_W = F_W + 1;

    cnp_phase_e       phase_q;
    logic             tail_q;
    logic [CNT_W-1:0] edge_cnt_q;

    logic             in_fire;
    logic             out_fire;
    logic             row_end_in;
    logic [LLR_W-1:0] mag_in;

    logic             v1_q, sgn1_q, last1_q;
    logic [LLR_W-1:0] mag1_q;
    logic [F_W-1:0]   f_mag1;

    logic             v2_q, sgn2_q, last2_q;
    logic [F_W-1:0]   f2_q;

    logic [SUM_W-1:0] sum_q;
    logic             par_q;

    logic [BUF_W-1:0] head;
    logic [CNT_W-1:0] buf_cnt;
    logic [SUM_W-1:0] ext_sum;
    logic [F_W-1:0]   mag_out;
    logic             out_sign;

    assign in_ready   = (phase_q == PH_COLLECT) && !tail_q;
    assign in_fire    = in_valid && in_ready;
    assign out_valid  = (phase_q == PH_EMIT);
    assign out_fire   = out_valid && out_ready;
    assign out_last   = (buf_cnt == CNT_W'(1));
    assign row_end_in = in_last || (edge_cnt_q == CNT_W'(MAX_DEG - 1));

    // Absolute value of the incoming LLR.
    always_comb begin
        mag_in = in_llr[LLR_W-1] ? (~in_llr + 1'b1) : in_llr;
    end

    // Stage 1: register sign and magnitude split.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q    <= 1'b0;
            sgn1_q  <= 1'b0;
            mag1_q  <= '0;
            last1_q <= 1'b0;
        end else begin
            v1_q    <= in_fire;
            sgn1_q  <= in_llr[LLR_W-1];
            mag1_q  <= mag_in;
            last1_q <= row_end_in;
        end
    end

    cnp_ftable #(.IN_W(LLR_W), .IDX_W(IDX_W), .FRAC(FRAC)) u_f_in (
        .mag  (mag1_q),
        .fval (f_mag1)
    );

    // Stage 2: register f value; sign takes its second delay here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q    <= 1'b0;
            sgn2_q  <= 1'b0;
            f2_q    <= '0;
            last2_q <= 1'b0;
        end else begin
            v2_q    <= v1_q;
            sgn2_q  <= sgn1_q;
            f2_q    <= f_mag1;
            last2_q <= last1_q;
        end
    end

    // Count accepted edges to enforce the maximum degree.
    always_ff @(posedge clk) begin
        if (!rst_n)       edge_cnt_q <= '0;
        else if (in_fire) edge_cnt_q <= row_end_in ? '0 : edge_cnt_q + 1'b1;
    end

    // Block input from row end acceptance until the row is drained.
    always_ff @(posedge clk) begin
        if (!rst_n)                      tail_q <= 1'b0;
        else if (in_fire && row_end_in)  tail_q <= 1'b1;
        else if (out_fire && out_last)   tail_q <= 1'b0;
    end

    // Switch between collect and emit passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_COLLECT;
        end else begin
            case (phase_q)
                PH_COLLECT: if (v2_q && last2_q)     phase_q <= PH_EMIT;
                PH_EMIT:    if (out_fire && out_last) phase_q <= PH_COLLECT;
                default:                              phase_q <= PH_COLLECT;
            endcase
        end
    end

    // Accumulate the f sum and sign parity; clear at row end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            par_q <= 1'b0;
        end else if (out_fire && out_last) begin
            sum_q <= '0;
            par_q <= 1'b0;
        end else if (v2_q) begin
            sum_q <= sum_q + SUM_W'(f2_q);
            par_q <= par_q ^ sgn2_q;
        end
    end

    cnp_edge_fifo #(.DEPTH(MAX_DEG), .W(BUF_W)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (v2_q),
        .din   ({sgn2_q, f2_q}),
        .pop   (out_fire),
        .dout  (head),
        .count (buf_cnt)
    );

    // Exclude the head edge from the totals.
    always_comb begin
        ext_sum  = sum_q - SUM_W'(head[F_W-1:0]);
        out_sign = par_q ^ head[F_W];
    end

    cnp_ftable #(.IN_W(SUM_W), .IDX_W(IDX_W), .FRAC(FRAC)) u_f_out (
        .mag  (ext_sum),
        .fval (mag_out)
    );

    // Apply the combined sign as a two's-complement negation.
    always_comb begin
        out_llr = out_sign ? (~LLR_W'(mag_out) + 1'b1) : LLR_W'(mag_out);
    end
endmodule

// File: rtl/cnp_serial_chk.sv
// Protocol checker for cnp_serial, bound to every instance.
// Assumes synchronous active-low reset on rst_n.
module cnp_serial_chk #(
    parameter int LLR_W = 8,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             out_valid,
    input logic             out_ready,
    input logic [LLR_W-1:0] out_llr,
    input logic             out_last
);
    localparam int TMAX = (1 << IDX_W) - 1;

    assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_llr) && $stable(out_last));

    assert_passes_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_stop_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |=> !in_ready);

    assert_resume_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> in_ready && !out_valid);

    assert_out_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_llr) <= TMAX) && ($signed(out_llr) >= -TMAX));
endmodule

bind cnp_serial cnp_serial_chk #(.LLR_W(LLR_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_llr   (out_llr),
    .out_last  (out_last)
);

// File: tb/cnp_serial_tb_top.sv
// Scoreboard bench: the driver pushes modelled outputs, the monitor compares.
module cnp_serial_tb_top;
    localparam int MAXD = 32;

    typedef struct {
        int    llr;
        bit    last;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_llr = '0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_llr;
    logic       out_last;

    int   errors = 0;
    int   checks = 0;
    bit   stall_on = 1'b0;
    bit   overlap_seen = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    cnp_serial dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_llr(in_llr), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_llr(out_llr), .out_last(out_last)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Table model from the R2 formula.
    function automatic int tval(input int m);
        int  i;
        real x;
        int  r;
        i = (m > 31) ? 31 : m;
        if (i == 0) i = 1;
        x = i / 4.0;
        r = $rtoi($ln((($exp(x) + 1.0) / ($exp(x) - 1.0))) * 4.0 + 0.5);
        return (r > 31) ? 31 : r;
    endfunction

    // Model a row (R3), push expectations, then drive the edges.
    task automatic send_row(input int v[$], input bit use_last, input string tag);
        int tot = 0;
        bit par = 0;
        foreach (v[k]) begin
            tot += tval((v[k] < 0) ? -v[k] : v[k]);
            par ^= (v[k] < 0);
        end
        foreach (v[k]) begin
            exp_t e;
            int   fo;
            int   m;
            bit   s;
            fo = tval((v[k] < 0) ? -v[k] : v[k]);
            m  = tval(tot - fo);
            s  = par ^ (v[k] < 0);
            e.llr  = s ? -m : m;
            e.last = (k == v.size() - 1);
            e.tag  = tag;
            q.push_back(e);
        end
        foreach (v[k]) begin
            bit ok;
            @(posedge clk);
            #1;
            in_valid = 1'b1;
            in_llr   = 8'(v[k]);
            in_last  = use_last && (k == v.size() - 1);
            do begin
                @(negedge clk);
                ok = in_ready;
                @(posedge clk);
            end while (!ok);
            #1;
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
        @(negedge clk);
        check(in_ready == 1'b0, use_last ? "R5 in_ready after last" : "R6 in_ready after cap",
              int'(in_ready), 0);
    endtask

    // Output back-pressure source.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = stall_on ? 1'($urandom % 2) : 1'b1;
        end
    end

    // Monitor: compare transfers, check held outputs during stalls, pass overlap.
    initial begin
        bit       prev_stall = 1'b0;
        bit [7:0] prev_llr = '0;
        bit       prev_last = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (in_ready && out_valid) overlap_seen = 1'b1;
                if (prev_stall) begin
                    check(out_valid && out_llr == prev_llr && out_last == prev_last,
                          "R7 stalled output held", int'($signed(out_llr)), int'($signed(prev_llr)));
                end
                if (out_valid && out_ready) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R4 unexpected output", int'($signed(out_llr)), 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(int'($signed(out_llr)) == e.llr, e.tag, int'($signed(out_llr)), e.llr);
                        check(out_last == e.last, "R4 out_last", int'(out_last), int'(e.last));
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_llr   = out_llr;
                prev_last  = out_last;
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    // Main sequence.
    initial begin
        int r[$];
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        r = '{4, 8, 12, 6};                 send_row(r, 1, "R3 positive row");
        r = '{-5, 9, -3, 14, 2, -20};       send_row(r, 1, "R3 mixed signs");
        r = '{127, -128, 0, 40, -1};        send_row(r, 1, "R2 saturation and zero");
        r = '{0, 0, 0};                     send_row(r, 1, "R2 zero entries");
        r = '{-17};                         send_row(r, 1, "R8 single edge negative");
        r = '{9};                           send_row(r, 1, "R8 single edge positive");
        r = '{-6, 11};                      send_row(r, 1, "R3 two edges");
        r.delete();
        for (int k = 0; k < MAXD; k++) r.push_back((k % 3 == 0) ? -(k + 1) : (k + 2));
        send_row(r, 0, "R6 capped row");
        stall_on = 1'b1;
        for (int n = 0; n < 12; n++) begin
            int d;
            r.delete();
            d = 1 + ($urandom % 12);
            for (int k = 0; k < d; k++) r.push_back(int'($urandom_range(0, 255)) - 128);
            send_row(r, 1, "R3 random row");
        end
        for (int w = 0; w < 2000 && (q.size() != 0 || !in_ready); w++) @(posedge clk);
        @(negedge clk);
        check(q.size() == 0, "R4 all outputs delivered", q.size(), 0);
        check(!overlap_seen, "R9 passes never overlap", int'(overlap_seen), 0);
        finish_run();
    end
endmodule